// File: doc/BRIEF.md
# Authenticated Firmware and Data Line Loader

This block is a command-driven copy engine. It moves either a firmware image or a block of data from external memory into a 96 KB local store, one 64-byte line at a time. A command is offered on a valid/ready pair, and one command is accepted per handshake. The block reads lines over a simple request/response port with one read outstanding. Each returned line goes out on a write port to the local store.

There are two kinds of command. A code load names an image with an 8-bit selector. It proceeds only if the external authentication-success input is high in the acceptance cycle. A data load names a line-aligned source address, a destination line and a line count. Three status outputs report progress and outcome:

- `busy` shows that a load is in progress.
- `img_valid` shows that a complete authenticated image is resident.
- `err` shows that the most recent accepted command was refused.

Top module: `fwl_loader`

## Requirements
- R1: After reset `busy`, `img_valid`, `err`, `rd_req_valid` and `ram_we` are low and `cmd_ready` is high.
- R2: `cmd_kind` 0 means code load and 1 means data load. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high exactly when the block is idle.
- R3: A legal code load copies N lines, N = `cmd_len[16:6]`. Line i is read from byte address ((`cmd_desc` << SLOT_SHIFT) + `cmd_addr[31:6]` + i) * 64 and written to local line i.
- R4: A code load accepted while `auth_ok` is low issues no read and no write. It leaves `img_valid` low and sets `err`.
- R5: A code load with `cmd_desc` equal to 0 is refused in the same way; selector values 1 to 255 are legal.
- R6: `img_valid` goes low in the cycle after any code load is accepted. It goes high in the cycle after the last line of a legal code load is written.
- R7: A data load reads from byte address (`cmd_addr[47:6]` + i) * 64 and writes local line `cmd_dst[16:6]` + i, for i = 0 .. `cmd_len[16:6]` - 1. Bits [63:48] and [5:0] of `cmd_addr` and bits [5:0] of `cmd_dst` and `cmd_len` are ignored.
- R8: A command with a line count of zero, or whose last line would lie at or beyond line STORE_LINES (1536), is refused. It sets `err` and writes nothing.
- R9: `busy` is high from the cycle after acceptance of a legal command until the cycle after its last line is written. A command held valid meanwhile is not taken until `busy` falls.
- R10: A data load never changes `img_valid`.
- R11: At most one read is outstanding. A read request holds its address until accepted, and each line's request follows the previous line's response.
- R12: An accepted legal command clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_kind | input | 1 | 0 code load, 1 data load |
| cmd_desc | input | 8 | Image selector for code loads |
| cmd_addr | input | 64 | Code: image offset in [31:6]; data: source address in [47:6] |
| cmd_dst | input | 17 | Data destination line in [16:6] |
| cmd_len | input | 17 | Line count in [16:6] |
| auth_ok | input | 1 | Authentication success, sampled at code-load acceptance |
| rd_req_valid | output | 1 | Line read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Byte address of the line, low 6 bits zero |
| rd_rsp_valid | input | 1 | Line data returned |
| rd_rsp_data | input | LINE_W | Returned line |
| ram_we | output | 1 | Local store write strobe |
| ram_line | output | LINE_AW | Local store line index |
| ram_wdata | output | LINE_W | Line written to the local store |
| busy | output | 1 | Load in progress |
| img_valid | output | 1 | Authenticated image resident |
| err | output | 1 | Last accepted command was refused |

## Verification
The sharpest overlap is the completion of a code load and the acceptance of the next code load. The first sets `img_valid`; the next one clears it in its first cycle. The bench provokes this by holding a second command valid throughout a running code load, so it is taken in the very first idle cycle. It then checks three things: `img_valid` is high when `cmd_ready` returns, it is low one cycle later, and only the first command's lines were written. The same held command also shows that nothing is accepted while a line response and its write are in flight.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
    // line size and command field position (fields hold units of one line)
    localparam int LINE_SHIFT = 6;
    localparam int FLD_LO     = 6;
    localparam int FLD_HI     = 16;
    localparam int FLD_W      = FLD_HI - FLD_LO + 1;

    localparam logic KIND_CODE = 1'b0;
    localparam logic KIND_DATA = 1'b1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/fwl_cmd_check.sv
// Decodes a command and decides whether it may run.
module fwl_cmd_check
    import fwl_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int STORE_LINES = 1536,
    parameter int SLOT_SHIFT  = 20,
    localparam int SRC_W      = ADDR_W - LINE_SHIFT,
    localparam int LINE_AW    = $clog2(STORE_LINES)
) (
    input  logic              kind,
    input  logic [7:0]        desc,
    input  logic              auth,
    input  logic [63:0]       addr,
    input  logic [FLD_HI:0]   dst_f,
    input  logic [FLD_HI:0]   len_f,
    output logic              ok,
    output logic [SRC_W-1:0]  src_line,
    output logic [LINE_AW-1:0] dst_line,
    output logic [FLD_W-1:0]  n_lines
);
    logic [FLD_W-1:0] dst_fld;
    logic [FLD_W:0]   end_line;
    logic             len_fits;
    logic             unused_bits;

    assign dst_fld  = dst_f[FLD_HI:FLD_LO];
    assign n_lines  = len_f[FLD_HI:FLD_LO];
    assign end_line = {1'b0, dst_fld} + {1'b0, n_lines};
    assign len_fits = (n_lines != '0) && (int'(n_lines) <= STORE_LINES);

    always_comb begin
        if (kind == KIND_CODE) begin
            src_line = (SRC_W'(desc) << SLOT_SHIFT) + SRC_W'(addr[31:LINE_SHIFT]);
            dst_line = '0;
            ok       = auth && (desc != 8'd0) && len_fits;
        end else begin
            src_line = addr[ADDR_W-1:LINE_SHIFT];
            dst_line = LINE_AW'(dst_fld);
            ok       = len_fits && (int'(end_line) <= STORE_LINES);
        end
    end

    assign unused_bits = ^{addr[63:ADDR_W], addr[LINE_SHIFT-1:0],
                           dst_f[FLD_LO-1:0], len_f[FLD_LO-1:0]};
endmodule

// File: rtl/fwl_seq.sv
// Line-by-line copy sequencer with status, two-process style.
module fwl_seq
    import fwl_pkg::*;
#(
    parameter int SRC_W       = 42,
    parameter int STORE_LINES = 1536,
    parameter int LINE_W      = 512,
    localparam int LINE_AW    = $clog2(STORE_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_kind,
    input  logic               chk_ok,
    input  logic [SRC_W-1:0]   chk_src,
    input  logic [LINE_AW-1:0] chk_dst,
    input  logic [FLD_W-1:0]   chk_lines,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [SRC_W+LINE_SHIFT-1:0] rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [LINE_W-1:0]  rd_rsp_data,
    output logic               ram_we,
    output logic [LINE_AW-1:0] ram_line,
    output logic [LINE_W-1:0]  ram_wdata,
    output logic               busy,
    output logic               img_valid,
    output logic               err
);
    typedef struct packed {
        seq_state_e         st;
        logic [SRC_W-1:0]   src;
        logic [LINE_AW-1:0] line;
        logic [FLD_W-1:0]   left;
        logic               is_code;
        logic               img;
        logic               err;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      accept;

    always_comb begin
        seq_d        = seq_q;
        cmd_ready    = (seq_q.st == SEQ_IDLE);
        accept       = cmd_valid && cmd_ready;
        rd_req_valid = (seq_q.st == SEQ_REQ);
        rd_req_addr  = {seq_q.src, {LINE_SHIFT{1'b0}}};
        ram_we       = (seq_q.st == SEQ_WAIT) && rd_rsp_valid;
        ram_line     = seq_q.line;
        ram_wdata    = rd_rsp_data;

        case (seq_q.st)
            SEQ_IDLE: begin
                if (accept) begin
                    seq_d.err = !chk_ok;
                    if (cmd_kind == KIND_CODE) begin
                        seq_d.img = 1'b0;
                    end
                    if (chk_ok) begin
                        seq_d.st      = SEQ_REQ;
                        seq_d.src     = chk_src;
                        seq_d.line    = chk_dst;
                        seq_d.left    = chk_lines;
                        seq_d.is_code = (cmd_kind == KIND_CODE);
                    end
                end
            end
            SEQ_REQ: begin
                if (rd_req_ready) begin
                    seq_d.st = SEQ_WAIT;
                end
            end
            SEQ_WAIT: begin
                if (rd_rsp_valid) begin
                    seq_d.src  = seq_q.src + SRC_W'(1);
                    seq_d.line = seq_q.line + LINE_AW'(1);
                    seq_d.left = seq_q.left - FLD_W'(1);
                    if (seq_q.left == FLD_W'(1)) begin
                        seq_d.st = SEQ_IDLE;
                        if (seq_q.is_code) begin
                            seq_d.img = 1'b1;
                        end
                    end else begin
                        seq_d.st = SEQ_REQ;
                    end
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.st != SEQ_IDLE);
    assign img_valid = seq_q.img;
    assign err       = seq_q.err;

    // R6
    img_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(img_valid) |-> $past(ram_we));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    // R8
    line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(ram_line) < STORE_LINES));

    // R10
    data_keeps_img_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_kind == KIND_DATA) |=> $stable(img_valid));

    // R8
    refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !chk_ok) |=> (!busy && err && !ram_we));
endmodule

// File: rtl/fwl_loader.sv
// Top: authenticated firmware / data line loader into a local store.
module fwl_loader
    import fwl_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int LINE_W      = 512,
    parameter int STORE_LINES = 1536,
    parameter int SLOT_SHIFT  = 20,
    localparam int LINE_AW    = $clog2(STORE_LINES),
    localparam int SRC_W      = ADDR_W - LINE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_kind,
    input  logic [7:0]         cmd_desc,
    input  logic [63:0]        cmd_addr,
    input  logic [16:0]        cmd_dst,
    input  logic [16:0]        cmd_len,
    input  logic               auth_ok,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [LINE_W-1:0]  rd_rsp_data,
    output logic               ram_we,
    output logic [LINE_AW-1:0] ram_line,
    output logic [LINE_W-1:0]  ram_wdata,
    output logic               busy,
    output logic               img_valid,
    output logic               err
);
    logic               chk_ok;
    logic [SRC_W-1:0]   chk_src;
    logic [LINE_AW-1:0] chk_dst;
    logic [FLD_W-1:0]   chk_lines;

    fwl_cmd_check #(
        .ADDR_W(ADDR_W), .STORE_LINES(STORE_LINES), .SLOT_SHIFT(SLOT_SHIFT)
    ) u_check (
        .kind(cmd_kind), .desc(cmd_desc), .auth(auth_ok), .addr(cmd_addr),
        .dst_f(cmd_dst), .len_f(cmd_len), .ok(chk_ok), .src_line(chk_src),
        .dst_line(chk_dst), .n_lines(chk_lines)
    );

    fwl_seq #(
        .SRC_W(SRC_W), .STORE_LINES(STORE_LINES), .LINE_W(LINE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .chk_ok(chk_ok), .chk_src(chk_src),
        .chk_dst(chk_dst), .chk_lines(chk_lines),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .ram_we(ram_we), .ram_line(ram_line),
        .ram_wdata(ram_wdata), .busy(busy), .img_valid(img_valid), .err(err)
    );

    // R4
    auth_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_kind == KIND_CODE && !auth_ok)
        |=> (!busy && !img_valid && err));

    // R5
    zero_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_kind == KIND_CODE && cmd_desc == 8'd0)
        |=> (!busy && !img_valid));
endmodule

// File: tb/tb_fwl_loader.sv
module tb_fwl_loader;
    localparam int CLK_P = 10;
    localparam int SLOT  = 20;

    typedef struct packed {
        logic        kind;
        logic [7:0]  desc;
        logic        auth;
        logic [63:0] addr;
        logic [16:0] dst;
        logic [16:0] len;
        logic        exp_ok;
        logic        exp_img;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd3,   1'b1, 64'h0000_0000_0000_1240, 17'h0,     17'h00100, 1'b1, 1'b1},
        '{1'b1, 8'd0,   1'b0, 64'hABCD_0012_3456_788F, 17'h002A5, 17'h000D1, 1'b1, 1'b1},
        '{1'b0, 8'd5,   1'b0, 64'h0000_0000_0000_0400, 17'h0,     17'h00080, 1'b0, 1'b0},
        '{1'b1, 8'd0,   1'b0, 64'h0000_0000_0001_0000, 17'h17E80, 17'h00180, 1'b1, 1'b0},
        '{1'b1, 8'd0,   1'b0, 64'h0000_0000_0002_0000, 17'h17EC0, 17'h00180, 1'b0, 1'b0},
        '{1'b0, 8'd0,   1'b1, 64'h0000_0000_0000_0000, 17'h0,     17'h00040, 1'b0, 1'b0},
        '{1'b0, 8'd255, 1'b1, 64'h0000_0000_FFFF_FFC7, 17'h0,     17'h00080, 1'b1, 1'b1},
        '{1'b1, 8'd0,   1'b0, 64'h0000_0000_0003_0000, 17'h00040, 17'h0003F, 1'b0, 1'b1},
        '{1'b0, 8'd7,   1'b1, 64'h0000_0000_0000_0000, 17'h0,     17'h18040, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_kind = 1'b0, auth_ok = 1'b0;
    logic [7:0]  cmd_desc = '0;
    logic [63:0] cmd_addr = '0;
    logic [16:0] cmd_dst = '0, cmd_len = '0;
    logic        cmd_ready, rd_req_valid, rd_req_ready, rd_rsp_valid;
    logic [47:0] rd_req_addr;
    logic [511:0] rd_rsp_data, ram_wdata;
    logic        ram_we, busy, img_valid, err;
    logic [10:0] ram_line;

    always #(CLK_P/2) clk = ~clk;

    fwl_loader dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_desc(cmd_desc), .cmd_addr(cmd_addr),
        .cmd_dst(cmd_dst), .cmd_len(cmd_len), .auth_ok(auth_ok),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .ram_we(ram_we), .ram_line(ram_line),
        .ram_wdata(ram_wdata), .busy(busy), .img_valid(img_valid), .err(err)
    );

    int checks = 0, fails = 0;
    int n_wr = 0, n_rd = 0, n_bad = 0, exp_n = 0;
    logic [47:0] exp_addr [64];
    logic [10:0] exp_line [64];
    bit done = 0;

    function automatic logic [511:0] mdata(input logic [47:0] a);
        return {16{a[31:0]}};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic add_exp(input logic [47:0] src, input int dst, input int lines);
        for (int i = 0; i < lines; i++) begin
            exp_addr[exp_n] = src + 48'(64 * i);
            exp_line[exp_n] = 11'(dst + i);
            exp_n++;
        end
    endtask

    task automatic clear_log();
        n_wr = 0; n_rd = 0; n_bad = 0; exp_n = 0;
    endtask

    function automatic logic [47:0] src_of(input vec_t v);
        if (v.kind == 1'b0)
            return (48'(v.desc) << (SLOT + 6)) + {16'h0, v.addr[31:6], 6'h0};
        return {v.addr[47:6], 6'h0};
    endfunction

    // memory model and observer: responses one cycle after the handshake
    logic        pend = 0;
    logic [47:0] pend_addr = '0;
    int          tick = 0;
    initial begin
        rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
        forever begin
            @(negedge clk);
            tick++;
            if (pend) begin
                rd_rsp_valid = 1'b1; rd_rsp_data = mdata(pend_addr); pend = 0;
            end else begin
                rd_rsp_valid = 1'b0;
            end
            rd_req_ready = (tick % 3) != 0;
            #2;
            if (ram_we) begin
                if (n_wr >= exp_n || ram_line !== exp_line[n_wr] ||
                    ram_wdata !== mdata(exp_addr[n_wr])) n_bad++;
                n_wr++;
            end
            if (rd_req_valid && rd_req_ready) begin
                if (n_rd >= exp_n || rd_req_addr !== exp_addr[n_rd]) n_bad++;
                n_rd++;
                pend = 1; pend_addr = rd_req_addr;
            end
        end
    end

    task automatic run_vec(input int idx);
        vec_t v = VECS[idx];
        int lines = int'(v.len[16:6]);
        int dst = (v.kind == 1'b0) ? 0 : int'(v.dst[16:6]);
        string tag;
        int guard = 0;
        if (v.exp_ok) tag = (v.kind == 1'b0) ? "R3" : "R7";
        else if (v.kind == 1'b0 && !v.auth) tag = "R4";
        else if (v.kind == 1'b0 && v.desc == 8'd0) tag = "R5";
        else tag = "R8";
        clear_log();
        if (v.exp_ok) add_exp(src_of(v), dst, lines);
        while (!cmd_ready) @(negedge clk);
        cmd_kind = v.kind; cmd_desc = v.desc; auth_ok = v.auth;
        cmd_addr = v.addr; cmd_dst = v.dst; cmd_len = v.len; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; auth_ok = 1'b0;
        chk(busy == v.exp_ok, "R9", busy, v.exp_ok);
        if (v.kind == 1'b0) chk(img_valid == 1'b0, "R6", img_valid, 0);
        while (busy && guard < 2000) begin @(negedge clk); guard++; end
        @(negedge clk);
        chk(n_wr == (v.exp_ok ? lines : 0), tag, n_wr, v.exp_ok ? lines : 0);
        chk(n_bad == 0, tag, n_bad, 0);
        chk(n_rd == n_wr, "R11", n_rd, n_wr);
        chk(err == !v.exp_ok, v.exp_ok ? "R12" : tag, err, !v.exp_ok);
        chk(img_valid == v.exp_img, (v.kind == 1'b1) ? "R10" : "R6", img_valid, v.exp_img);
        chk(cmd_ready == 1'b1, "R2", cmd_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int guard;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);
        chk(busy == 1'b0, "R1", busy, 0);
        chk(img_valid == 1'b0, "R1", img_valid, 0);
        chk(err == 1'b0, "R1", err, 0);
        chk(rd_req_valid == 1'b0 && ram_we == 1'b0, "R1", {rd_req_valid, ram_we}, 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // completion of a code load meets a held next command (R9, R6, R5)
        clear_log();
        add_exp((48'd9 << (SLOT + 6)) + 48'h80, 0, 2);
        while (!cmd_ready) @(negedge clk);
        cmd_kind = 1'b0; cmd_desc = 8'd9; auth_ok = 1'b1;
        cmd_addr = 64'h80; cmd_dst = '0; cmd_len = 17'h00080; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_desc = 8'd0; cmd_len = 17'h00040;
        chk(cmd_ready == 1'b0, "R9", cmd_ready, 0);
        guard = 0;
        while (!cmd_ready && guard < 2000) begin @(negedge clk); guard++; end
        chk(img_valid == 1'b1, "R6", img_valid, 1);
        @(negedge clk);
        cmd_valid = 1'b0; auth_ok = 1'b0;
        chk(img_valid == 1'b0, "R6", img_valid, 0);
        chk(err == 1'b1 && busy == 1'b0, "R5", {err, busy}, 2'b10);
        repeat (2) @(negedge clk);
        chk(n_wr == 2, "R9", n_wr, 2);
        chk(n_bad == 0, "R9", n_bad, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule